// File: doc/BRIEF.md
# Rotating Priority Resolver with Nesting

This block handles arbitration and in-service bookkeeping for one eight-line interrupt controller. It takes a vector of pending requests and a mask, and picks the highest-priority unmasked line. Priority is measured from a movable base pointer. The block raises its interrupt output only when that candidate outranks every line already being serviced. Request capture and any software register access belong to neighbouring logic.

An acknowledge strobe moves the current winner into the in-service vector. In auto end-of-interrupt mode the winner is retired at once instead of being recorded, and the base can optionally rotate past it. A command port carries a 3-bit code and a 3-bit level. It retires lines in one of two ways: the highest-priority in-service line, or a line named by the level. It can also rotate the base or toggle the rotate-on-auto-EOI flag. A mode input lets the primary controller leave its cascade line out of the nesting check, so a secondary controller can present nested requests through that line.

Top module: `prio_nest_resolver`

## Requirements
- R1: After reset the base pointer is 0, the in-service vector is 0, the rotate-on-auto-EOI flag is 0 and `irq_o` is 0.
- R2: Only lines set in `req_i` and clear in `mask_i` compete. They are ranked starting at the base line and wrapping modulo 8, and rank 0 is the highest. `win_line_o` shows the top-ranked competitor combinationally, and shows 0 when there is none.
- R3: `irq_o` is a register. It is loaded on each clock with whether the top competitor's rank is strictly below the rank of the highest in-service line, using the state as it stands after that edge. An equal rank blocks the request.
- R4: When `nested_mode_i` is 1 and the instance is the primary, the cascade line (line 2 by default) is not counted when the in-service rank is computed.
- R5: `ack_i` sets the in-service bit of `win_line_o` only when a request is being raised. An acknowledge with no raised request leaves the in-service vector unchanged, and no in-service bit rises without an acknowledge.
- R6: With `auto_eoi_i` at 1, an acknowledge sets no in-service bit. If the rotate flag is also 1, the base becomes the winner plus 1, modulo 8.
- R7: Command codes 1 and 5 clear the highest-ranked in-service bit, ranked from the base with no cascade exemption. Code 5 also sets the base to that line plus 1. When nothing is in service, neither code has any effect.
- R8: Code 3 clears the in-service bit named by `cmd_level_i`. Code 7 does the same and also sets the base to the level plus 1.
- R9: Code 6 sets the base to the level plus 1, modulo 8, and clears nothing. Code 2 changes nothing.
- R10: Code 0 clears the rotate-on-auto-EOI flag and code 4 sets it.
- R11: When a command and an acknowledge arrive in the same cycle, the command acts on the in-service vector as it was before the acknowledge, and the bit set by the acknowledge is kept. A base written by the command takes precedence over a rotation caused by the acknowledge, and the acknowledge uses the rotate flag as it was before the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 8 | Pending request vector |
| mask_i | input | 8 | Mask, 1 blocks the line |
| ack_i | input | 1 | Acknowledge strobe |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_code_i | input | 3 | Command code (0..7) |
| cmd_level_i | input | 3 | Command line or level operand |
| auto_eoi_i | input | 1 | Auto end-of-interrupt mode |
| nested_mode_i | input | 1 | Cascade-line exemption mode |
| irq_o | output | 1 | Registered interrupt output |
| win_line_o | output | 3 | Top-ranked competing line |
| isr_o | output | 8 | In-service vector |

## Verification
An acknowledge and an end-of-interrupt command can land on the same clock edge, and so can an acknowledge and a base-changing command. The bench provokes the first case by acknowledging line 1 while a non-specific EOI retires line 3, then checks that the in-service vector holds only line 1. It provokes the second case by acknowledging under auto-EOI with rotation enabled while code 6 writes the base. The winner reported with all lines pending then shows whether the command's base won.

// File: rtl/prio_nest_pkg.sv
package prio_nest_pkg;

    typedef enum logic [2:0] {
        CMD_ROT_OFF    = 3'd0,
        CMD_EOI_NS     = 3'd1,
        CMD_NOP        = 3'd2,
        CMD_EOI_SP     = 3'd3,
        CMD_ROT_ON     = 3'd4,
        CMD_EOI_NS_ROT = 3'd5,
        CMD_SET_BASE   = 3'd6,
        CMD_EOI_SP_ROT = 3'd7
    } prio_cmd_e;

endpackage

// File: rtl/prio_rank_scan.sv
module prio_rank_scan #(
    parameter int N  = 8,
    parameter int IW = $clog2(N),
    parameter int RW = $clog2(N + 1)
) (
    input  logic [N-1:0]  vec_i,
    input  logic [IW-1:0] base_i,
    output logic [RW-1:0] rank_o,
    output logic [IW-1:0] line_o
);

    // Downward loop so the lowest rank found is the one kept.
    always_comb begin
        rank_o = RW'(N);
        line_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec_i[base_i + IW'(i)]) begin
                rank_o = RW'(i);
                line_o = base_i + IW'(i);
            end
        end
    end

endmodule

// File: rtl/prio_cmd_decode.sv
module prio_cmd_decode
    import prio_nest_pkg::*;
#(
    parameter int IW = 3
) (
    input  logic          valid_i,
    input  logic [2:0]    code_i,
    input  logic [IW-1:0] level_i,
    input  logic          top_found_i,
    input  logic [IW-1:0] top_line_i,
    output logic          clr_vld_o,
    output logic [IW-1:0] clr_line_o,
    output logic          base_wr_o,
    output logic [IW-1:0] base_val_o,
    output logic          rot_wr_o,
    output logic          rot_val_o
);

    prio_cmd_e code_c;
    assign code_c = prio_cmd_e'(code_i);

    always_comb begin
        clr_vld_o  = 1'b0;
        clr_line_o = '0;
        base_wr_o  = 1'b0;
        base_val_o = '0;
        rot_wr_o   = 1'b0;
        rot_val_o  = 1'b0;
        if (valid_i) begin
            unique case (code_c)
                CMD_ROT_OFF: begin
                    rot_wr_o  = 1'b1;
                    rot_val_o = 1'b0;
                end
                CMD_ROT_ON: begin
                    rot_wr_o  = 1'b1;
                    rot_val_o = 1'b1;
                end
                CMD_EOI_NS, CMD_EOI_NS_ROT: begin
                    if (top_found_i) begin
                        clr_vld_o  = 1'b1;
                        clr_line_o = top_line_i;
                        if (code_c == CMD_EOI_NS_ROT) begin
                            base_wr_o  = 1'b1;
                            base_val_o = top_line_i + IW'(1);
                        end
                    end
                end
                CMD_EOI_SP: begin
                    clr_vld_o  = 1'b1;
                    clr_line_o = level_i;
                end
                CMD_EOI_SP_ROT: begin
                    clr_vld_o  = 1'b1;
                    clr_line_o = level_i;
                    base_wr_o  = 1'b1;
                    base_val_o = level_i + IW'(1);
                end
                CMD_SET_BASE: begin
                    base_wr_o  = 1'b1;
                    base_val_o = level_i + IW'(1);
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/prio_nest_resolver.sv
module prio_nest_resolver #(
    parameter int N            = 8,
    parameter int CASCADE_LINE = 2,
    parameter bit IS_PRIMARY   = 1'b1,
    localparam int IW          = $clog2(N),
    localparam int RW          = $clog2(N + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req_i,
    input  logic [N-1:0]  mask_i,
    input  logic          ack_i,
    input  logic          cmd_valid_i,
    input  logic [2:0]    cmd_code_i,
    input  logic [IW-1:0] cmd_level_i,
    input  logic          auto_eoi_i,
    input  logic          nested_mode_i,
    output logic          irq_o,
    output logic [IW-1:0] win_line_o,
    output logic [N-1:0]  isr_o
);

    typedef struct packed {
        logic [IW-1:0] base;
        logic [N-1:0]  isr;
        logic          rot;
    } nest_state_t;

    localparam logic [N-1:0] CASC_BIT = N'(1) << CASCADE_LINE;

    nest_state_t   cur_q, nxt_d;
    logic          irq_q, irq_d;
    logic [IW-1:0] base_q;

    logic [N-1:0]  elig_c;
    logic          exempt_c;
    logic [N-1:0]  svc_vec_c, svc_vec_n;
    logic [RW-1:0] req_rank_c, svc_rank_c, top_rank_c;
    logic [RW-1:0] req_rank_n, svc_rank_n;
    logic [IW-1:0] win_c, top_line_c, unused_line_a, unused_line_b, unused_line_c;
    logic          hit_c;

    logic          clr_vld, base_wr, rot_wr, rot_val;
    logic [IW-1:0] clr_line, base_val;

    assign elig_c    = req_i & ~mask_i;
    assign exempt_c  = nested_mode_i && IS_PRIMARY;
    assign svc_vec_c = exempt_c ? (cur_q.isr & ~CASC_BIT) : cur_q.isr;
    assign svc_vec_n = exempt_c ? (nxt_d.isr & ~CASC_BIT) : nxt_d.isr;
    assign base_q    = cur_q.base;

    // Present-state rankings
    prio_rank_scan #(.N(N)) u_req (
        .vec_i(elig_c), .base_i(cur_q.base), .rank_o(req_rank_c), .line_o(win_c));
    prio_rank_scan #(.N(N)) u_svc (
        .vec_i(svc_vec_c), .base_i(cur_q.base), .rank_o(svc_rank_c), .line_o(unused_line_a));
    prio_rank_scan #(.N(N)) u_top (
        .vec_i(cur_q.isr), .base_i(cur_q.base), .rank_o(top_rank_c), .line_o(top_line_c));

    assign hit_c = req_rank_c < svc_rank_c;

    prio_cmd_decode #(.IW(IW)) u_cmd (
        .valid_i     (cmd_valid_i),
        .code_i      (cmd_code_i),
        .level_i     (cmd_level_i),
        .top_found_i (top_rank_c != RW'(N)),
        .top_line_i  (top_line_c),
        .clr_vld_o   (clr_vld),
        .clr_line_o  (clr_line),
        .base_wr_o   (base_wr),
        .base_val_o  (base_val),
        .rot_wr_o    (rot_wr),
        .rot_val_o   (rot_val)
    );

    always_comb begin
        logic [N-1:0] clr_m;
        logic [N-1:0] set_m;
        logic         take;
        nxt_d = cur_q;
        take  = ack_i && hit_c;
        clr_m = clr_vld ? (N'(1) << clr_line) : '0;
        set_m = (take && !auto_eoi_i) ? (N'(1) << win_c) : '0;
        nxt_d.isr = (cur_q.isr & ~clr_m) | set_m;
        if (take && auto_eoi_i && cur_q.rot)
            nxt_d.base = win_c + IW'(1);
        if (base_wr)
            nxt_d.base = base_val;
        if (rot_wr)
            nxt_d.rot = rot_val;
    end

    // Next-state rankings feed the registered request output
    prio_rank_scan #(.N(N)) u_req_n (
        .vec_i(elig_c), .base_i(nxt_d.base), .rank_o(req_rank_n), .line_o(unused_line_b));
    prio_rank_scan #(.N(N)) u_svc_n (
        .vec_i(svc_vec_n), .base_i(nxt_d.base), .rank_o(svc_rank_n), .line_o(unused_line_c));

    assign irq_d = req_rank_n < svc_rank_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
            irq_q <= 1'b0;
        end else begin
            cur_q <= nxt_d;
            irq_q <= irq_d;
        end
    end

    assign irq_o      = irq_q;
    assign win_line_o = win_c;
    assign isr_o      = cur_q.isr;

endmodule

// File: rtl/prio_nest_checker.sv
module prio_nest_checker #(
    parameter int N  = 8,
    parameter int IW = $clog2(N)
) (
    input logic          clk,
    input logic          rst_n,
    input logic [N-1:0]  req_i,
    input logic [N-1:0]  mask_i,
    input logic          ack_i,
    input logic          cmd_valid_i,
    input logic [2:0]    cmd_code_i,
    input logic          auto_eoi_i,
    input logic          hit,
    input logic [IW-1:0] base,
    input logic          irq_o,
    input logic [IW-1:0] win_line_o,
    input logic [N-1:0]  isr_o
);

    p_ack_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && hit && !auto_eoi_i) |=> isr_o[$past(win_line_o)]);

    p_no_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_i |=> ((isr_o & ~$past(isr_o)) == '0));

    p_auto_noset_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && auto_eoi_i && !cmd_valid_i) |=> (isr_o == $past(isr_o)));

    p_irq_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(|(req_i & ~mask_i)));

    p_empty_eoi_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && (cmd_code_i == 3'd1 || cmd_code_i == 3'd5) && isr_o == '0 && !ack_i)
        |=> (isr_o == '0 && base == $past(base)));

    p_one_new_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($countones(isr_o & ~$past(isr_o)) <= 1));

endmodule

bind prio_nest_resolver prio_nest_checker #(.N(N)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (req_i),
    .mask_i      (mask_i),
    .ack_i       (ack_i),
    .cmd_valid_i (cmd_valid_i),
    .cmd_code_i  (cmd_code_i),
    .auto_eoi_i  (auto_eoi_i),
    .hit         (hit_c),
    .base        (base_q),
    .irq_o       (irq_o),
    .win_line_o  (win_line_o),
    .isr_o       (isr_o)
);

// File: tb/prio_nest_resolver_bench.sv
`timescale 1ns/100ps
module prio_nest_resolver_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] req_i = '0, mask_i = '0;
    logic       ack_i = 1'b0, cmd_valid_i = 1'b0;
    logic [2:0] cmd_code_i = '0, cmd_level_i = '0;
    logic       auto_eoi_i = 1'b0, nested_mode_i = 1'b0;
    logic       irq_o;
    logic [2:0] win_line_o;
    logic [7:0] isr_o;

    int n_run = 0, n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    prio_nest_resolver u_prio_nest_resolver (
        .clk, .rst_n, .req_i, .mask_i, .ack_i, .cmd_valid_i, .cmd_code_i,
        .cmd_level_i, .auto_eoi_i, .nested_mode_i, .irq_o, .win_line_o, .isr_o);

    task automatic chk(input string tag, input int got, input int exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_ack();
        ack_i = 1'b1; step(); ack_i = 1'b0;
    endtask

    task automatic do_cmd(input int code, input int lvl);
        cmd_valid_i = 1'b1; cmd_code_i = 3'(code); cmd_level_i = 3'(lvl);
        step(); cmd_valid_i = 1'b0;
    endtask

    task automatic win_all(input string tag, input int exp);
        req_i = 8'hFF; #1 chk(tag, win_line_o, exp);
    endtask

    task automatic t_reset();
        chk("R1 irq", irq_o, 0);
        chk("R1 isr", isr_o, 0);
        win_all("R1 base", 0);
        req_i = 0;
    endtask

    task automatic t_ranking();
        req_i = 8'hA0; #1 chk("R2 win", win_line_o, 5);
        step(); chk("R3 irq raised", irq_o, 1);
        mask_i = 8'h20; #1 chk("R2 masked", win_line_o, 7);
        mask_i = 0;
    endtask

    task automatic t_nesting();
        req_i = 8'h20; do_ack();
        chk("R5 ack sets", isr_o, 8'h20);
        chk("R3 equal blocks", irq_o, 0);
        req_i = 8'h28; #1 chk("R2 win3", win_line_o, 3);
        step(); chk("R3 higher raises", irq_o, 1);
        do_ack(); chk("R5 nested ack", isr_o, 8'h28);
        do_cmd(1, 0); chk("R7 ns eoi", isr_o, 8'h20);
        do_cmd(1, 0); chk("R7 ns eoi 2", isr_o, 0);
        do_cmd(1, 0); chk("R7 empty isr", isr_o, 0);
        win_all("R7 empty base", 0);
        req_i = 0; do_ack(); chk("R5 idle ack", isr_o, 0);
    endtask

    task automatic t_cascade();
        nested_mode_i = 1'b1; req_i = 8'h04; do_ack();
        chk("R4 isr", isr_o, 8'h04);
        chk("R4 exempt irq", irq_o, 1);
        nested_mode_i = 1'b0; step();
        chk("R4 no exempt", irq_o, 0);
        do_cmd(3, 2); chk("R8 specific", isr_o, 0);
        req_i = 0;
    endtask

    task automatic t_base();
        do_cmd(6, 4); win_all("R9 base5", 5);
        req_i = 8'h11; #1 chk("R9 wrap", win_line_o, 0);
        req_i = 0; do_cmd(2, 0); win_all("R9 nop", 5);
        chk("R9 nop isr", isr_o, 0);
        req_i = 0; do_cmd(6, 7);
    endtask

    task automatic t_rotate_eoi();
        req_i = 8'h08; do_ack();
        req_i = 8'h0A; do_ack(); chk("R5 two", isr_o, 8'h0A);
        do_cmd(5, 0); chk("R7 rot eoi", isr_o, 8'h08);
        win_all("R7 rot base", 2);
        do_cmd(7, 3); chk("R8 sp rot", isr_o, 0);
        win_all("R8 rot base", 4);
        req_i = 0;
    endtask

    task automatic t_auto();
        do_cmd(6, 7); auto_eoi_i = 1'b1;
        req_i = 8'h10; do_ack(); chk("R6 no set", isr_o, 0);
        win_all("R6 no rotate", 0);
        req_i = 0; do_cmd(4, 0);
        req_i = 8'h10; do_ack(); win_all("R10 rot on", 5);
        req_i = 0; do_cmd(0, 0);
        req_i = 8'h40; do_ack(); chk("R6 isr", isr_o, 0);
        win_all("R10 rot off", 5);
        req_i = 0; auto_eoi_i = 1'b0;
    endtask

    task automatic t_same_cycle();
        do_cmd(6, 7);
        req_i = 8'h08; do_ack();
        req_i = 8'h02; ack_i = 1'b1; do_cmd(1, 0); ack_i = 1'b0;
        chk("R11 ack+eoi", isr_o, 8'h02);
        req_i = 0; do_cmd(1, 0);
        auto_eoi_i = 1'b1; do_cmd(4, 0);
        req_i = 8'h08; ack_i = 1'b1; do_cmd(6, 5); ack_i = 1'b0;
        win_all("R11 cmd base wins", 6);
        chk("R11 auto isr", isr_o, 0);
        req_i = 0; auto_eoi_i = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ranking();
        t_nesting();
        t_cascade();
        t_base();
        t_rotate_eoi();
        t_auto();
        t_same_cycle();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got hang expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule